// File: doc/BRIEF.md
# Down-Counting Timer with Buffered Reload

This block is a 16-bit timer counter that counts down. On each enabled clock it decrements. When it has reached zero, the next enabled clock loads it with the reload value, which is called an underflow. A reload register holds that value. Software writes the reload register through a small synchronous register port. The written value either reaches the active reload register at once, or it waits in a buffer copy until the next update event. A control bit chooses between the two.

An update event comes from one of three sources: an underflow, a self-clearing software request bit, or an external trigger input. An update-hold bit blocks all update events. While it is set, the buffer copy is not transferred, no pulse appears and the sticky flag is not set. The counter still restarts from the active reload value on underflow. Each update event produces a one-cycle pulse on an output port and sets a sticky flag. Software clears the flag.

Register map (3-bit address, 16-bit data):

| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | control | write/read | bit 0 = run, bit 1 = update hold, bit 2 = buffer enable |
| 1 | status | write/read | bit 0 = sticky update flag |
| 2 | event | write/read | bit 0 = software update request |
| 3 | count | write/read | counter value |
| 4 | reload | write/read | buffer copy of the reload value |
| 5 | active reload | read only | active reload value |

Read data is registered. It shows the addressed register one clock after the address is presented.

Top module: `dntimer`

## Requirements
- R1: While run (control bit 0) is 1, each clock decrements a non-zero count by one. A count of zero is loaded with the reload value, which is an underflow.
- R2: An underflow while update hold (control bit 1) is 0 is an update event. Every update event drives `upd_pulse` high for exactly the one cycle after it, in the same cycle that the reloaded count appears.
- R3: While update hold is 1, no source produces an update event: `upd_pulse` stays 0, the flag is not set and the active reload value keeps its value. An underflow still reloads the count from the active reload value.
- R4: With buffer enable (control bit 2) at 0, a write to address 4 changes the active reload value (address 5) in the same edge.
- R5: With buffer enable at 1, a write to address 4 leaves address 5 unchanged. On the next update event the buffered value becomes active, and the count is loaded with that same value.
- R6: Writing 1 to bit 0 of address 2 causes an update event on the following clock: the count is loaded with the reload value, and the bit reads back 0 afterwards.
- R7: A high level on `trig_in` at a clock edge is an update event at that edge. The count is loaded with the reload value even while run is 0.
- R8: Every update event sets the status flag (address 1, bit 0). The flag stays set until software writes 0 to that bit, and writing 1 leaves it unchanged.
- R9: While run is 0 and no update event or count write occurs, the count holds its value.
- R10: After reset the count is 0, both reload registers hold 0xFFFF, and control, status and event read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| trig_in | input | 1 | External update trigger, active high |
| cnt_o | output | 16 | Current count |
| upd_pulse | output | 1 | One-cycle pulse after each update event |

## Verification
The bench sweeps every reload value from 0 to 7, starting the count at that value and running three full periods. A bench model predicts the count and the pulse on every cycle. This sweep separates off-by-one errors in reload timing, including the value 0, where an underflow happens on every cycle. The same model is run with update hold set while a buffered value is pending. That run shows whether the counter reloads from the old active value and whether the pending value stays put. Software requests and trigger pulses are applied with the counter stopped, so a reload caused by them cannot be mistaken for counting. The same requests are then repeated with update hold set, to show that they are blocked.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_EVGEN  = 3'd2,
    A_COUNT  = 3'd3,
    A_RELOAD = 3'd4,
    A_ACTIVE = 3'd5
  } reg_addr_e;

  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_HOLD = 1;
  localparam int unsigned CTL_BUF  = 2;
  localparam int unsigned CTL_W    = 3;

  typedef struct packed {
    logic buf_en;
    logic hold;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/dntimer_regs.sv
module dntimer_regs
  import dntimer_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  cnt,
  input  logic [W-1:0]  arr_pre,
  input  logic [W-1:0]  arr_act,
  input  logic          flag,
  output ctrl_t         ctrl,
  output logic          sw_req,
  output logic          cnt_wr,
  output logic          arr_wr,
  output logic          flag_clr,
  output logic [W-1:0]  rdata
);
  localparam int unsigned PADC = W - CTL_W;
  localparam int unsigned PAD1 = W - 1;

  logic sel_ctrl, sel_stat, sel_ev;

  always_comb begin
    sel_ctrl = wr_en && (addr == AW'(A_CTRL));
    sel_stat = wr_en && (addr == AW'(A_STAT));
    sel_ev   = wr_en && (addr == AW'(A_EVGEN));
    cnt_wr   = wr_en && (addr == AW'(A_COUNT));
    arr_wr   = wr_en && (addr == AW'(A_RELOAD));
    flag_clr = sel_stat && !wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (sel_ctrl) begin
      ctrl.run    <= wdata[CTL_RUN];
      ctrl.hold   <= wdata[CTL_HOLD];
      ctrl.buf_en <= wdata[CTL_BUF];
    end
  end

  // request bit lives exactly one cycle unless rewritten
  always_ff @(posedge clk) begin
    if (rst)        sw_req <= 1'b0;
    else if (sel_ev) sw_req <= wdata[0];
    else            sw_req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        AW'(A_CTRL):   rdata <= {{PADC{1'b0}}, ctrl};
        AW'(A_STAT):   rdata <= {{PAD1{1'b0}}, flag};
        AW'(A_EVGEN):  rdata <= {{PAD1{1'b0}}, sw_req};
        AW'(A_COUNT):  rdata <= cnt;
        AW'(A_RELOAD): rdata <= arr_pre;
        AW'(A_ACTIVE): rdata <= arr_act;
        default:       rdata <= '0;
      endcase
    end
  end

  a_r6_req_selfclear: assert property (@(posedge clk) disable iff (rst)
    (sw_req && !sel_ev) |=> !sw_req);
endmodule

// File: rtl/dntimer_reload.sv
module dntimer_reload
  import dntimer_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         buf_en,
  input  logic         arr_wr,
  input  logic [W-1:0] wdata,
  input  logic         upd_evt,
  output logic [W-1:0] arr_pre,
  output logic [W-1:0] arr_act,
  output logic [W-1:0] reload_val
);
  localparam logic [W-1:0] RST_VAL = '1;

  always_ff @(posedge clk) begin
    if (rst) arr_pre <= RST_VAL;
    else if (arr_wr) arr_pre <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) arr_act <= RST_VAL;
    else if (arr_wr && !buf_en) arr_act <= wdata;
    else if (upd_evt) arr_act <= arr_pre;
  end

  // on an update the count takes the value that becomes active
  always_comb reload_val = upd_evt ? arr_pre : arr_act;

  a_r5_active_hold: assert property (@(posedge clk) disable iff (rst)
    (buf_en && !upd_evt) |=> $stable(arr_act));
  a_r4_direct_write: assert property (@(posedge clk) disable iff (rst)
    (arr_wr && !buf_en) |=> (arr_act == arr_pre));
endmodule

// File: rtl/dntimer_core.sv
module dntimer_core
  import dntimer_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_t        ctrl,
  input  logic         sw_req,
  input  logic         trig_in,
  input  logic         cnt_wr,
  input  logic [W-1:0] wdata,
  input  logic         flag_clr,
  input  logic [W-1:0] reload_val,
  output logic         upd_evt,
  output logic [W-1:0] cnt,
  output logic         flag,
  output logic         upd_pulse
);
  logic uf;

  always_comb begin
    uf      = ctrl.run && (cnt == '0);
    upd_evt = !ctrl.hold && (uf || sw_req || trig_in);
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (uf || upd_evt) cnt <= reload_val;
    else if (cnt_wr)        cnt <= wdata;
    else if (ctrl.run)      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           flag <= 1'b0;
    else if (upd_evt)  flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) upd_pulse <= 1'b0;
    else     upd_pulse <= upd_evt;
  end

  a_r1_decrement: assert property (@(posedge clk) disable iff (rst)
    (ctrl.run && cnt != '0 && !upd_evt && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1));
  a_r3_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    ctrl.hold |=> !upd_pulse);
  a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
    upd_pulse |-> flag);
  a_r9_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !upd_evt && !cnt_wr) |=> $stable(cnt));
endmodule

// File: rtl/dntimer.sv
module dntimer
  import dntimer_pkg::*;
#(
  parameter int unsigned W  = CNT_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          trig_in,
  output logic [W-1:0]  cnt_o,
  output logic          upd_pulse
);
  ctrl_t        ctrl;
  logic         sw_req, cnt_wr, arr_wr, flag_clr, upd_evt, flag;
  logic [W-1:0] cnt, arr_pre, arr_act, reload_val;

  dntimer_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .arr_pre(arr_pre), .arr_act(arr_act), .flag(flag),
    .ctrl(ctrl), .sw_req(sw_req), .cnt_wr(cnt_wr), .arr_wr(arr_wr),
    .flag_clr(flag_clr), .rdata(rdata)
  );

  dntimer_reload #(.W(W)) u_reload (
    .clk(clk), .rst(rst), .buf_en(ctrl.buf_en), .arr_wr(arr_wr),
    .wdata(wdata), .upd_evt(upd_evt), .arr_pre(arr_pre),
    .arr_act(arr_act), .reload_val(reload_val)
  );

  dntimer_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .ctrl(ctrl), .sw_req(sw_req), .trig_in(trig_in),
    .cnt_wr(cnt_wr), .wdata(wdata), .flag_clr(flag_clr),
    .reload_val(reload_val), .upd_evt(upd_evt), .cnt(cnt), .flag(flag),
    .upd_pulse(upd_pulse)
  );

  assign cnt_o = cnt;
endmodule

// File: tb/dntimer_test.sv
module dntimer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        trig_in = 1'b0;
  logic [15:0] cnt_o;
  logic        upd_pulse;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // bench model state
  int m_cnt, m_act, m_pre;
  bit m_hold;

  always #2 clk = ~clk;

  dntimer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .trig_in(trig_in), .cnt_o(cnt_o), .upd_pulse(upd_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 3'(a);
    @(posedge clk);
    #1 v = int'(rdata);
  endtask

  // run n cycles with run=1, compare each cycle against the model
  task automatic run_model(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int prev;
      bit exp_p;
      prev = m_cnt;
      exp_p = (prev == 0) && !m_hold;
      if (exp_p) m_act = m_pre;
      m_cnt = (prev == 0) ? m_act : prev - 1;
      @(negedge clk);
      chk(int'(cnt_o) == m_cnt, req, int'(cnt_o), m_cnt);
      chk(upd_pulse == exp_p, "R2", int'(upd_pulse), int'(exp_p));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(cnt_o == 16'd0, "R10", int'(cnt_o), 0);
    rd(4, v); chk(v == 16'hFFFF, "R10", v, 65535);
    rd(5, v); chk(v == 16'hFFFF, "R10", v, 65535);
    rd(0, v); chk(v == 0, "R10", v, 0);
    rd(1, v); chk(v == 0, "R10", v, 0);
    rd(2, v); chk(v == 0, "R10", v, 0);

    // R1/R2/R4 sweep reload 0..7, buffer off
    for (int a = 0; a < 8; a++) begin
      wr(0, 0);
      wr(4, a);
      rd(5, v); chk(v == a, "R4", v, a);
      wr(3, a);
      @(negedge clk);
      chk(int'(cnt_o) == a, "R9", int'(cnt_o), a);
      m_cnt = a; m_act = a; m_pre = a; m_hold = 1'b0;
      wr(0, 1);
      run_model(3 * (a + 1), "R1");
    end

    // R8 sticky flag: write 1 keeps, write 0 clears
    wr(0, 0);
    rd(1, v); chk(v == 1, "R8", v, 1);
    wr(1, 1);
    rd(1, v); chk(v == 1, "R8", v, 1);
    wr(1, 0);
    rd(1, v); chk(v == 0, "R8", v, 0);

    // R3 hold with pending buffered value
    wr(4, 3);                 // buffer off: active=3
    wr(0, 4 | 2);             // buffer on, hold on, stopped
    wr(4, 6);
    rd(5, v); chk(v == 3, "R5", v, 3);
    wr(3, 1);
    m_cnt = 1; m_act = 3; m_pre = 6; m_hold = 1'b1;
    wr(0, 7);
    run_model(9, "R3");
    wr(0, 6);
    rd(5, v); chk(v == 3, "R3", v, 3);
    rd(1, v); chk(v == 0, "R3", v, 0);
    // R3 forced requests blocked while held
    wr(3, 40);
    wr(2, 1);
    @(negedge clk);
    chk(cnt_o == 16'd40, "R3", int'(cnt_o), 40);
    chk(upd_pulse == 1'b0, "R3", int'(upd_pulse), 0);
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    chk(cnt_o == 16'd40, "R3", int'(cnt_o), 40);
    chk(upd_pulse == 1'b0, "R3", int'(upd_pulse), 0);

    // R5 buffered transfer on underflow, counting resumes with hold off
    wr(3, 2);
    m_cnt = 2; m_act = 3; m_pre = 6; m_hold = 1'b0;
    wr(0, 5);
    run_model(12, "R5");
    wr(0, 4);
    rd(5, v); chk(v == 6, "R5", v, 6);

    // R6 software request, stopped counter, buffer on
    wr(4, 11);
    wr(3, 50);
    wr(2, 1);
    @(negedge clk);
    chk(cnt_o == 16'd11, "R6", int'(cnt_o), 11);
    chk(upd_pulse == 1'b1, "R6", int'(upd_pulse), 1);
    rd(2, v); chk(v == 0, "R6", v, 0);
    rd(5, v); chk(v == 11, "R6", v, 11);
    @(negedge clk);
    chk(upd_pulse == 1'b0, "R2", int'(upd_pulse), 0);

    // R7 external trigger while stopped
    wr(4, 23);
    wr(3, 99);
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    chk(cnt_o == 16'd23, "R7", int'(cnt_o), 23);
    chk(upd_pulse == 1'b1, "R7", int'(upd_pulse), 1);
    @(negedge clk);
    chk(cnt_o == 16'd23, "R9", int'(cnt_o), 23);
    chk(upd_pulse == 1'b0, "R7", int'(upd_pulse), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule